// File: doc/BRIEF.md
# Multi-Format PCM Serial Audio Receiver

This block takes stereo PCM audio from up to four serial data lines. All lines share one bit clock and one word clock. Each line yields a left and a right 24-bit two's-complement sample per stereo frame. A 3-bit format code picks one of five framings:

- right-aligned 16-bit
- right-aligned 20-bit
- right-aligned 24-bit
- left-aligned 24-bit
- I2S 24-bit

The bit clock and word clock are not used as clocks. They are brought into the fast system clock domain, and their edges are found there. The serial clock may therefore come from any source, as long as it is slow enough against the system clock.

The format code is held in a small register. It loads from a parallel input and resets to the left-aligned 24-bit code. Its lowest bit is ORed with an external strap pin. When a stereo frame is complete, every lane's left and right words change together, and a one-cycle strobe marks the update. Downstream logic, such as an interpolation filter, reads all lanes at that strobe.

Top module: `pcm_serial_rx`

## Requirements
- R1: Each serial bit is taken at a rising edge of `bick_in`, MSB first, as two's complement. Data and `lrck_in` change only while `bick_in` is low. Each `bick_in` phase lasts at least 3 `clk` cycles.
- R2: Format code 000 (right-aligned 16-bit): the sample is the last 16 bits before a word-clock change. Bit 15 is sign-extended into output bits 23:16.
- R3: Format code 001 (right-aligned 20-bit): the sample is the last 20 bits before a word-clock change. Bit 19 is sign-extended into bits 23:20.
- R4: Format code 100 (right-aligned 24-bit): the sample is the last 24 bits before a word-clock change.
- R5: Format code 010 (left-aligned 24-bit):
  - The MSB is the first bit after a word-clock change, and the next 23 bits follow.
  - Later bits in the half-frame are ignored.
  - Bits the half-frame does not carry read as zero.
  - 16-bit or 20-bit data sent with zeroed low bits comes out unchanged.
- R6: Format code 011 (I2S): the MSB is the second bit after a word-clock change, and 24 bits follow. `lrck_in` low marks the left channel.
- R7: In every format other than I2S, `lrck_in` high marks the left channel and low marks the right channel.
- R8: Format register:
  - After reset the stored code is 010. `fmt_load` high stores `fmt_data` at a clock edge.
  - The code in use is the stored code with bit 0 ORed with `fmt_pin`.
  - Codes 101, 110 and 111 act as 010.
- R9: Output strobe and holding:
  - `valid_o` pulses for one cycle per stereo frame, after a right half-frame that followed a left one.
  - The pulse comes at the first bit of the next half-frame.
  - All outputs change only in that cycle and hold between pulses. After reset, the outputs are zero and `valid_o` is low.
- R10: Every lane is deframed at the same time and on its own. Lane i occupies bits [24*i+23:24*i] of `left_out` and `right_out`.
- R11: Minimum half-frame lengths work: 16 bits per channel for format 000, 20 for 001, and 24 for 010 and 100.
- R12: The half-frame in progress when the first word-clock change after reset is seen yields no sample and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| bick_in | input | 1 | Serial bit clock |
| lrck_in | input | 1 | Serial word clock (channel select) |
| sdata_in | input | LANES | Serial data, one bit per lane |
| fmt_load | input | 1 | Store `fmt_data` into the format register |
| fmt_data | input | 3 | Format code to store |
| fmt_pin | input | 1 | Strap pin ORed into format bit 0 |
| left_out | output | 24*LANES | Left samples, lane i at bits 24*i+23:24*i |
| right_out | output | 24*LANES | Right samples, same lane layout |
| valid_o | output | 1 | One-cycle strobe when a stereo frame is updated |

## Verification
The bench drives each framing with the bit-clock count per half-frame set to the minimum for that framing and also to 32. At the minimum count, a receiver that counts one bit too many or too few shifts every sample by a factor of two or picks up a junk bit.

Random junk fills the bits outside the sample window:
- A receiver that does not align right-justified data to the word-clock change puts junk into the high bits.
- A receiver that does not stop after 24 bits in left-aligned mode corrupts the low bits.

Extreme values in the first frame of each batch catch missing sign extension. The I2S batches, including the one selected only through the strap pin, catch a swapped channel polarity or a missing one-bit delay as exchanged or halved words. A strobe before the first complete frame, or a missing strobe, shows up as an unexpected or lost frame in the bench's frame queue.

// File: rtl/pcm_rx_pkg.sv
// Package: shared format codes, decoded format controls and the decode function.
package pcm_rx_pkg;

    localparam int unsigned SMP_W = 24;

    typedef enum logic [2:0] {
        FMT_LSB16 = 3'd0,
        FMT_LSB20 = 3'd1,
        FMT_MSB24 = 3'd2,
        FMT_I2S24 = 3'd3,
        FMT_LSB24 = 3'd4
    } fmt_code_e;

    typedef struct packed {
        logic       right_align;  // sample ends at the word-clock change
        logic [4:0] width;        // sample width in bits
        logic [1:0] lead;         // bits skipped after the change (left-aligned kinds)
        logic       left_high;    // word-clock level that marks the left channel
    } fmt_cfg_t;

    // Turn a 3-bit format code into framing controls; unknown codes act as left-aligned 24-bit.
    function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
        fmt_cfg_t c;
        c.right_align = 1'b0;
        c.width       = 5'd24;
        c.lead        = 2'd0;
        c.left_high   = 1'b1;
        case (code)
            FMT_LSB16: begin c.right_align = 1'b1; c.width = 5'd16; end
            FMT_LSB20: begin c.right_align = 1'b1; c.width = 5'd20; end
            FMT_LSB24: begin c.right_align = 1'b1; end
            FMT_I2S24: begin c.lead = 2'd1; c.left_high = 1'b0; end
            default:   ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pcm_fmt_select.sv
// Format select: holds the stored format code, ORs the strap pin into bit 0 and
// decodes the result. Assumes fmt_pin is static or already synchronous to clk.
module pcm_fmt_select
    import pcm_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fmt_load,
    input  logic [2:0] fmt_data,
    input  logic     fmt_pin,
    output logic [2:0] fmt_q,
    output logic [2:0] fmt_eff,
    output fmt_cfg_t cfg
);

    // Stored code: resets to left-aligned 24-bit, loads on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        fmt_q <= FMT_MSB24;
        else if (fmt_load) fmt_q <= fmt_data;
    end

    // Code in use: strap pin forces bit 0.
    assign fmt_eff = {fmt_q[2:1], fmt_q[0] | fmt_pin};

    // Framing controls for the deframers.
    assign cfg = decode_fmt(fmt_eff);

endmodule

// File: rtl/pcm_edge_detect.sv
// Edge detect: brings bit clock, word clock and data lines into the clk domain
// through SYNC_STAGES flops and flags each rising bit-clock edge. All inputs share
// one synchronizer depth, so the word-clock and data values seen at the strobe are
// the ones present at that edge. Assumes each bit-clock phase lasts at least
// SYNC_STAGES+1 clk cycles and that data settles while the bit clock is low.
module pcm_edge_detect #(
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bick_in,
    input  logic             lrck_in,
    input  logic [LANES-1:0] sdata_in,
    output logic             bit_stb,
    output logic             lr_smp,
    output logic [LANES-1:0] data_smp
);

    localparam int W = LANES + 2;
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][W-1:0] stage;
    logic                          bick_d;

    // Synchronizer chain for all serial inputs together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            for (int s = SYNC_STAGES - 1; s > 0; s--) stage[s] <= stage[s-1];
            stage[0] <= {bick_in, lrck_in, sdata_in};
        end
    end

    // Rising-edge flag and the sampled word-clock and data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bick_d   <= 1'b0;
            bit_stb  <= 1'b0;
            lr_smp   <= 1'b0;
            data_smp <= '0;
        end else begin
            bick_d   <= stage[LAST][W-1];
            bit_stb  <= stage[LAST][W-1] & ~bick_d;
            lr_smp   <= stage[LAST][W-2];
            data_smp <= stage[LAST][LANES-1:0];
        end
    end

endmodule

// File: rtl/pcm_half_tracker.sv
// Half-frame tracker: counts bit-clock edges since the last word-clock change and
// flags the end of each half-frame. A half-frame ends at the first bit whose
// word-clock level differs from the previous bit's level. The half-frame in
// progress at reset is never reported. The count saturates at its top value.
module pcm_half_tracker #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             lr_smp,
    input  logic             left_high,
    output logic             half_end,
    output logic             end_left,
    output logic [CNT_W-1:0] bit_idx
);

    logic             lr_prev;
    logic             seen;
    logic             started;
    logic [CNT_W-1:0] count;
    logic             lr_change;

    // Change detection and this bit's index within its half-frame.
    always_comb begin
        lr_change = seen & (lr_smp != lr_prev);
        half_end  = bit_stb & lr_change & started;
        end_left  = (lr_prev == left_high);
        bit_idx   = lr_change ? '0 : count;
    end

    // Track the word-clock level, alignment and the saturating bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev <= 1'b0;
            seen    <= 1'b0;
            started <= 1'b0;
            count   <= '0;
        end else if (bit_stb) begin
            lr_prev <= lr_smp;
            seen    <= 1'b1;
            started <= started | lr_change;
            count   <= (&bit_idx) ? bit_idx : bit_idx + 1'b1;
        end
    end

endmodule

// File: rtl/pcm_lane_deframer.sv
// Lane deframer: turns one serial data line into left and right words.
// - Right-aligned formats keep the last bits in a shift register and sign-extend
//   them when the half-frame ends.
// - Left-aligned formats place each bit into an accumulator by its index in the
//   half-frame.
// Left words wait in a holding register until the matching right word commits.
module pcm_lane_deframer
    import pcm_rx_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              din,
    input  logic              half_end,
    input  logic              end_left,
    input  logic              commit,
    input  logic [CNT_W-1:0]  bit_idx,
    input  fmt_cfg_t          cfg,
    output logic [SMP_W-1:0]  left_o,
    output logic [SMP_W-1:0]  right_o
);

    logic [SMP_W-1:0] sh;
    logic [SMP_W-1:0] acc;
    logic [SMP_W-1:0] acc_next;
    logic [SMP_W-1:0] left_hold;
    logic [SMP_W-1:0] shifted;
    logic [SMP_W-1:0] lsb_word;
    logic [SMP_W-1:0] word;
    logic [4:0]       shamt;
    logic [CNT_W-1:0] lead_ext;
    logic [CNT_W-1:0] pos;
    logic             in_win;

    // Sign-extend the right-aligned tail: shift the sample MSB to the top,
    // then shift back arithmetically.
    always_comb begin
        shamt    = 5'(SMP_W) - cfg.width;
        shifted  = sh << shamt;
        lsb_word = SMP_W'($signed(shifted) >>> shamt);
        word     = cfg.right_align ? lsb_word : acc;
    end

    // Left-aligned placement: bit index minus lead gives the MSB-first position.
    always_comb begin
        lead_ext = CNT_W'(cfg.lead);
        pos      = bit_idx - lead_ext;
        in_win   = (bit_idx >= lead_ext) && (pos < CNT_W'(SMP_W));
        acc_next = half_end ? '0 : acc;
        for (int b = 0; b < SMP_W; b++) begin
            if (in_win && pos == CNT_W'(SMP_W - 1 - b)) acc_next[b] = din;
        end
    end

    // Shift, accumulate, hold the left word and commit the stereo pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            acc       <= '0;
            left_hold <= '0;
            left_o    <= '0;
            right_o   <= '0;
        end else if (bit_stb) begin
            sh  <= {sh[SMP_W-2:0], din};
            acc <= acc_next;
            if (half_end && end_left) left_hold <= word;
            if (commit) begin
                left_o  <= left_hold;
                right_o <= word;
            end
        end
    end

endmodule

// File: rtl/pcm_serial_rx.sv
// Multi-format PCM serial receiver (top level).
// - Edge detect samples the serial inputs on the system clock.
// - One half-frame tracker serves every lane.
// - Each lane has its own deframer.
// A stereo frame commits when a right half-frame ends after a left one; valid_o
// rises in the same cycle the outputs change.
// Assumes the bit clock is slower than clk/(2*(SYNC_STAGES+1)).
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_MAX     = 511
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bick_in,
    input  logic                   lrck_in,
    input  logic [LANES-1:0]       sdata_in,
    input  logic                   fmt_load,
    input  logic [2:0]             fmt_data,
    input  logic                   fmt_pin,
    output logic [LANES*SMP_W-1:0] left_out,
    output logic [LANES*SMP_W-1:0] right_out,
    output logic                   valid_o
);

    localparam int CNT_W = $clog2(CNT_MAX + 1);

    logic [2:0]       fmt_q;
    logic [2:0]       fmt_eff;
    fmt_cfg_t         cfg;
    logic             bit_stb;
    logic             lr_smp;
    logic [LANES-1:0] data_smp;
    logic             half_end;
    logic             end_left;
    logic [CNT_W-1:0] bit_idx;
    logic             have_left;
    logic             commit;

    pcm_fmt_select u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_load (fmt_load),
        .fmt_data (fmt_data),
        .fmt_pin  (fmt_pin),
        .fmt_q    (fmt_q),
        .fmt_eff  (fmt_eff),
        .cfg      (cfg)
    );

    pcm_edge_detect #(.LANES(LANES), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bick_in  (bick_in),
        .lrck_in  (lrck_in),
        .sdata_in (sdata_in),
        .bit_stb  (bit_stb),
        .lr_smp   (lr_smp),
        .data_smp (data_smp)
    );

    pcm_half_tracker #(.CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .lr_smp    (lr_smp),
        .left_high (cfg.left_high),
        .half_end  (half_end),
        .end_left  (end_left),
        .bit_idx   (bit_idx)
    );

    // A right half-frame commits only when a left one came just before it.
    assign commit = half_end & ~end_left & have_left;

    // Remember whether the last finished half-frame was left; register the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_left <= 1'b0;
            valid_o   <= 1'b0;
        end else begin
            if (half_end) have_left <= end_left;
            valid_o <= commit;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pcm_lane_deframer #(.CNT_W(CNT_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .bit_stb  (bit_stb),
            .din      (data_smp[g]),
            .half_end (half_end),
            .end_left (end_left),
            .commit   (commit),
            .bit_idx  (bit_idx),
            .cfg      (cfg),
            .left_o   (left_out[g*SMP_W +: SMP_W]),
            .right_o  (right_out[g*SMP_W +: SMP_W])
        );
    end

endmodule

// File: rtl/pcm_serial_rx_chk.sv
// Checker: timing properties of the receiver's strobe, outputs and format register.
// Bound to every pcm_serial_rx instance.
module pcm_serial_rx_chk #(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_o,
    input logic [LANES*24-1:0] left_out,
    input logic [LANES*24-1:0] right_out,
    input logic [2:0]          fmt_q,
    input logic [2:0]          fmt_eff,
    input logic                bit_stb
);

    // R9: the strobe lasts one cycle.
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: outputs move only together with the strobe.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_out) && $stable(right_out)));

    // R9: a strobe follows a detected bit-clock edge.
    p_valid_after_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bit_stb));

    // R8: the stored format code is 010 right after reset.
    p_fmt_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (fmt_q == 3'b010));

    // R2: lane 0 left sample is sign-extended from bit 15.
    p_sext16_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt_eff == 3'd0) |->
        ($countones(left_out[23:15]) == 0 || $countones(left_out[23:15]) == 9));

    // R3: lane 0 right sample is sign-extended from bit 19.
    p_sext20_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt_eff == 3'd1) |->
        ($countones(right_out[23:19]) == 0 || $countones(right_out[23:19]) == 5));

endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_o   (valid_o),
    .left_out  (left_out),
    .right_out (right_out),
    .fmt_q     (fmt_q),
    .fmt_eff   (fmt_eff),
    .bit_stb   (bit_stb)
);

// File: tb/pcm_serial_rx_test.sv
// Bench for pcm_serial_rx.
// - Random samples with a fixed seed, directed extreme values in each batch's first frame.
// - Expected words come from the framing rules; a monitor compares every strobe.
module pcm_serial_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 4;
    localparam int HB         = 3;   // clk cycles per bit-clock phase

    typedef struct packed {
        logic [NL*24-1:0] l;
        logic [NL*24-1:0] r;
    } frame_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bick_in = 1'b0;
    logic             lrck_in = 1'b0;
    logic [NL-1:0]    sdata_in = '0;
    logic             fmt_load = 1'b0;
    logic [2:0]       fmt_data = 3'd0;
    logic             fmt_pin = 1'b0;
    logic [NL*24-1:0] left_out;
    logic [NL*24-1:0] right_out;
    logic             valid_o;

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    string  cur_tag = "";
    frame_t expq[$];
    frame_t last_exp;

    pcm_serial_rx #(.LANES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .bick_in(bick_in), .lrck_in(lrck_in),
        .sdata_in(sdata_in), .fmt_load(fmt_load), .fmt_data(fmt_data),
        .fmt_pin(fmt_pin), .left_out(left_out), .right_out(right_out),
        .valid_o(valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int width_of(int f);
        return (f == 0) ? 16 : (f == 1) ? 20 : 24;
    endfunction

    function automatic bit is_rj(int f);
        return (f == 0 || f == 1 || f == 4);
    endfunction

    // Serial bit at index idx of a half-frame carrying word w.
    function automatic logic ser_bit(int f, logic [23:0] w, int bph, int idx, logic junk);
        int n;
        int off;
        if (is_rj(f)) begin
            n = width_of(f);
            if (idx >= bph - n) return w[n-1-(idx-(bph-n))];
            return junk;
        end
        off = (f == 3) ? 1 : 0;
        if (idx >= off && idx - off < 24) return w[23-(idx-off)];
        return junk;
    endfunction

    // Expected output word from the framing rules (R2 to R6).
    function automatic logic [23:0] exp_word(int f, logic [23:0] w, int bph);
        logic [23:0] e;
        logic [23:0] mask;
        int n;
        int off;
        e = '0;
        if (is_rj(f)) begin
            n = width_of(f);
            mask = 24'((32'd1 << n) - 1);
            e = w & mask;
            if (w[n-1]) e = e | ~mask;
        end else begin
            off = (f == 3) ? 1 : 0;
            for (int j = 0; j < 24; j++) if (j + off < bph) e[23-j] = w[23-j];
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, logic [NL*24-1:0] act, logic [NL*24-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Send one half-frame: data and word clock change while the bit clock is low.
    task automatic send_half(logic lr, int bph, logic [NL*24-1:0] words, int f);
        for (int idx = 0; idx < bph; idx++) begin
            lrck_in = lr;
            for (int l = 0; l < NL; l++)
                sdata_in[l] = ser_bit(f, words[l*24 +: 24], bph, idx, 1'($urandom_range(0, 1)));
            repeat (HB) @(negedge clk);
            bick_in = 1'b1;
            repeat (HB) @(negedge clk);
            bick_in = 1'b0;
        end
    endtask

    function automatic logic [NL*24-1:0] rand_words();
        logic [NL*24-1:0] w;
        for (int l = 0; l < NL; l++) w[l*24 +: 24] = 24'($urandom);
        return w;
    endfunction

    // One batch: reset, optional format load, a priming half, frames, a flush half.
    task automatic run_batch(bit do_load, logic [2:0] code, logic pin, int nframes,
                             int bph, bit short_data, string tag);
        logic [2:0]       eff;
        int               f;
        logic             lhi;
        logic [NL*24-1:0] wl;
        logic [NL*24-1:0] wr;
        frame_t           fr;
        cur_tag = tag;
        bick_in = 1'b0;
        fmt_pin = pin;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o == 1'b0 && left_out == '0 && right_out == '0,
              "R9 reset state", left_out, '0);
        if (do_load) begin
            fmt_load = 1'b1;
            fmt_data = code;
            @(negedge clk);
            fmt_load = 1'b0;
            eff = {code[2:1], code[0] | pin};
        end else begin
            eff = {2'b01, pin};
        end
        f   = (eff > 3'd4) ? 2 : int'(eff);
        lhi = (f == 3) ? 1'b0 : 1'b1;
        send_half(~lhi, bph, rand_words(), f);   // R12: priming half yields nothing
        for (int k = 0; k < nframes; k++) begin
            if (k == 0) begin
                wl = {24'h000001, 24'hFFFFFF, 24'h800000, 24'h7FFFFF};
                wr = {24'h7F8000, 24'h0F0000, 24'hFF7FFF, 24'h808000};
            end else begin
                wl = rand_words();
                wr = rand_words();
            end
            if (short_data) begin
                for (int l = 0; l < NL; l++) begin
                    wl[l*24 +: 24] = wl[l*24 +: 24] & ((k % 2 == 0) ? 24'hFFFF00 : 24'hFFFFF0);
                    wr[l*24 +: 24] = wr[l*24 +: 24] & ((k % 2 == 0) ? 24'hFFFF00 : 24'hFFFFF0);
                end
            end
            for (int l = 0; l < NL; l++) begin
                fr.l[l*24 +: 24] = exp_word(f, wl[l*24 +: 24], bph);
                fr.r[l*24 +: 24] = exp_word(f, wr[l*24 +: 24], bph);
            end
            expq.push_back(fr);
            last_exp = fr;
            send_half(lhi, bph, wl, f);
            send_half(~lhi, bph, wr, f);
        end
        send_half(lhi, bph, rand_words(), f);    // flush: commits the last right word
        repeat (10) @(negedge clk);
        check(expq.size() == 0, {tag, " R9 frame count"}, NL*24'(expq.size()), '0);
        expq.delete();
        check(left_out == last_exp.l && right_out == last_exp.r,
              {tag, " R9 hold"}, left_out, last_exp.l);
    endtask

    // Monitor: compare each strobed frame with the next expected one, lane by lane (R10).
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (expq.size() == 0) begin
                check(1'b0, {cur_tag, " R12 unexpected strobe"}, left_out, '0);
            end else begin
                frame_t e;
                e = expq.pop_front();
                for (int l = 0; l < NL; l++) begin
                    check(left_out[l*24 +: 24] == e.l[l*24 +: 24],
                          $sformatf("%s R10 lane%0d left", cur_tag, l), left_out, e.l);
                    check(right_out[l*24 +: 24] == e.r[l*24 +: 24],
                          $sformatf("%s R10 lane%0d right", cur_tag, l), right_out, e.r);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        run_batch(1, 3'd0, 0, 5, 16, 0, "R2 R11 R1 R7");
        run_batch(1, 3'd0, 0, 5, 32, 0, "R2 R7");
        run_batch(1, 3'd1, 0, 5, 20, 0, "R3 R11");
        run_batch(1, 3'd1, 0, 4, 32, 0, "R3");
        run_batch(1, 3'd4, 0, 5, 24, 0, "R4 R11");
        run_batch(1, 3'd4, 0, 4, 32, 0, "R4");
        run_batch(1, 3'd2, 0, 5, 32, 1, "R5 short data");
        run_batch(1, 3'd2, 0, 4, 24, 0, "R5 R11");
        run_batch(1, 3'd3, 0, 5, 32, 0, "R6");
        run_batch(1, 3'd3, 0, 3, 24, 0, "R6 short half");
        run_batch(1, 3'd2, 1, 4, 32, 0, "R8 pin selects R6");
        run_batch(1, 3'd0, 1, 4, 32, 0, "R8 pin selects R3");
        run_batch(1, 3'd5, 0, 4, 32, 0, "R8 code 101");
        run_batch(0, 3'd0, 0, 4, 32, 0, "R8 reset code");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule